// File: doc/BRIEF.md
# Dual Page Buffer with Count Loading

This block keeps two page stores of 256 bytes each. In word mode each store holds 128 words. A host fills the currently selected store with a short bus sequence of writes. The first write is a load command. The next two writes carry the low and the high byte of an item count. The data items follow, each written with its array address. Another command toggles which store is selected. A page-write command then pushes the selected store's items out on an array write port, one item per clock, at consecutive addresses that start at the destination given with the command.

The count is biased: a low count byte of 00h means one item. The high count byte must be zero, so that a transfer stays within one 256-byte segment. The address written with the first data item becomes the store's source address. A page write is refused unless its destination equals that source address. Refusals set an error flag. Each store has its own ready flag, which drops while that store is being written out.

Top module: `pbuf_top`

## Requirements
- R1: After reset, `activeSel` is 0, `bufReady` is 2'b11, `errFlag` is 0 and `arrWe` is 0.
- R2: A byte-mode load with low count byte N leads to N+1 items in the page write. The page write outputs them in load order, one per clock, with `arrData` = {8'h00, byte}, `arrWord` = 0 and `arrAddr` = destination + k for item k. Item 0 appears in the cycle after the page-write command edge.
- R3: A word-mode load (`wordMode`=1 at the load command) takes both count bytes from `busData[7:0]` and ignores `busData[15:8]`. A low count of 00h moves exactly one 16-bit word, with `arrWord` = 1.
- R4: A high count byte other than 00h sets `errFlag` in the next cycle and ends the sequence. No item is stored, and the store keeps its earlier contents. The next bus write is decoded as a command.
- R5: In word mode, a low count byte of 80h or above is refused in the same way as R4, because the store holds at most 128 words.
- R6: The swap command (`busOp`=2) toggles `activeSel`. Loads and page writes use the selected store, and each store keeps its own contents, source address and count.
- R7: A page write (`busOp`=3) whose `busAddr` differs from the selected store's source address sets `errFlag` and writes nothing.
- R8: A page write to a store that has never completed a load sets `errFlag` and writes nothing.
- R9: While store b is being written out, `bufReady[b]` is 0 and the other ready bit stays 1.
- R10: Bus writes made while a page write is streaming are ignored.
- R11: A load command, a swap command or an accepted page write clears `errFlag`. NOP cycles (`busOp`=0) leave it unchanged.
- R12: The source address is the `busAddr` of the fourth bus write of a load, which is the first data item after the command and the two count writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordMode | input | 1 | 1 = 16-bit items, 0 = 8-bit items; sampled at the load command |
| busWr | input | 1 | Host bus write strobe |
| busOp | input | 2 | Command code on a command write: 0 NOP, 1 load, 2 swap, 3 page write |
| busAddr | input | ADDR_W | Item address, or destination on a page write |
| busData | input | 16 | Count byte in [7:0], or item data |
| activeSel | output | 1 | Selected store |
| bufReady | output | 2 | Per-store ready flag |
| errFlag | output | 1 | Refused count or refused page write |
| arrWe | output | 1 | Array write strobe |
| arrWord | output | 1 | Item on the array port is a word |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | 16 | Array write data |

## Verification
All outputs come from registered state. Each outcome therefore shows up in the cycle after the edge that samples the causing bus write. That holds for the toggled selection, for the raised or cleared error flag, and for item 0 of a stream with its ready bit low. Item k of a stream appears k cycles after item 0, and both ready bits are high again in the cycle after the last item. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. It compares every output against that model on the next falling edge. Directed checks read the same outputs exactly one falling edge after the bus write that causes them.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_SWAP   = 2'd2,
    OP_PAGEWR = 2'd3
  } busOp_e;

  typedef struct packed {
    logic       wrEn;
    logic       wrWord;
    logic       bufSel;
    logic       capSrc;
    logic [7:0] wrIdx;
  } dpStrobe_t;
endpackage

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
  import pbuf_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordMode,
  input  logic              busWr,
  input  logic [1:0]        busOp,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busData,
  input  logic [ADDR_W-1:0] srcAddrAct,
  output dpStrobe_t         stb,
  output logic              streamOn,
  output logic [7:0]        rdIdx,
  output logic              streamBuf,
  output logic              streamWord,
  output logic [ADDR_W-1:0] destAddr,
  output logic              activeSel,
  output logic              errFlag,
  output logic [1:0]        bufReady
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_CNTL, S_CNTH, S_ITEM, S_STREAM} state_e;
  state_e state;

  logic [IDX_W-1:0] cntLow, itemIdx, rdCnt;
  logic [IDX_W-1:0] bufCnt [2];
  logic [1:0]       bufValid, bufWord;
  logic             ldWord;
  logic             pageOk, cntHighBad;

  assign pageOk     = bufValid[activeSel] && (busAddr == srcAddrAct);
  assign cntHighBad = (busData[7:0] != 8'h00) || (ldWord && cntLow[IDX_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cntLow    <= '0;
      itemIdx   <= '0;
      rdCnt     <= '0;
      bufCnt[0] <= '0;
      bufCnt[1] <= '0;
      bufValid  <= '0;
      bufWord   <= '0;
      ldWord    <= 1'b0;
      activeSel <= 1'b0;
      streamBuf <= 1'b0;
      errFlag   <= 1'b0;
      destAddr  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (busWr) begin
          unique case (busOp_e'(busOp))
            OP_LOAD: begin
              state   <= S_CNTL;
              ldWord  <= wordMode;
              errFlag <= 1'b0;
            end
            OP_SWAP: begin
              activeSel <= ~activeSel;
              errFlag   <= 1'b0;
            end
            OP_PAGEWR: begin
              if (pageOk) begin
                state     <= S_STREAM;
                rdCnt     <= '0;
                streamBuf <= activeSel;
                destAddr  <= busAddr;
                errFlag   <= 1'b0;
              end else begin
                errFlag <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        S_CNTL: if (busWr) begin
          cntLow <= busData[IDX_W-1:0];
          state  <= S_CNTH;
        end
        S_CNTH: if (busWr) begin
          if (cntHighBad) begin
            errFlag <= 1'b1;
            state   <= S_IDLE;
          end else begin
            itemIdx <= '0;
            state   <= S_ITEM;
          end
        end
        S_ITEM: if (busWr) begin
          itemIdx <= itemIdx + 1'b1;
          if (itemIdx == cntLow) begin
            state               <= S_IDLE;
            bufCnt[activeSel]   <= cntLow;
            bufWord[activeSel]  <= ldWord;
            bufValid[activeSel] <= 1'b1;
          end
        end
        S_STREAM: begin
          rdCnt <= rdCnt + 1'b1;
          if (rdCnt == bufCnt[streamBuf]) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.wrEn   = (state == S_ITEM) && busWr;
    stb.wrWord = ldWord;
    stb.bufSel = activeSel;
    stb.capSrc = stb.wrEn && (itemIdx == '0);
    stb.wrIdx  = 8'(itemIdx);
  end

  assign streamOn   = (state == S_STREAM);
  assign rdIdx      = 8'(rdCnt);
  assign streamWord = bufWord[streamBuf];
  assign bufReady   = streamOn ? (streamBuf ? 2'b01 : 2'b10) : 2'b11;

  // R6
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && busWr && busOp == OP_SWAP) |=> (activeSel != $past(activeSel)));

  // R4
  cnt_high_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CNTH && busWr && busData[7:0] != 8'h00) |=> (errFlag && state == S_IDLE));

  // R7
  bad_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && busWr && busOp == OP_PAGEWR && busAddr != srcAddrAct) |=> (errFlag && !streamOn));

  // R2
  stream_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamOn && rdCnt == bufCnt[streamBuf]) |=> !streamOn);

  // R10
  stream_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamOn && busWr) |=> $stable(activeSel));
endmodule

// File: rtl/pbuf_data.sv
module pbuf_data
  import pbuf_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busData,
  input  logic              activeSel,
  input  logic              streamOn,
  input  logic [7:0]        rdIdx,
  input  logic              streamBuf,
  input  logic              streamWord,
  input  logic [ADDR_W-1:0] destAddr,
  output logic [ADDR_W-1:0] srcAddrAct,
  output logic              arrWe,
  output logic              arrWord,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [15:0]       arrData
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  logic [7:0]        mem [2][PAGE_BYTES];
  logic [ADDR_W-1:0] srcAddr [2];
  logic [IDX_W-1:0]  wrLo, rdLo;

  assign wrLo = stb.wrWord ? {stb.wrIdx[IDX_W-2:0], 1'b0} : stb.wrIdx[IDX_W-1:0];
  assign rdLo = streamWord ? {rdIdx[IDX_W-2:0], 1'b0} : rdIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      mem[stb.bufSel][wrLo] <= busData[7:0];
      if (stb.wrWord) mem[stb.bufSel][wrLo | IDX_W'(1)] <= busData[15:8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr[0] <= '0;
      srcAddr[1] <= '0;
    end else if (stb.capSrc) begin
      srcAddr[stb.bufSel] <= busAddr;
    end
  end

  assign srcAddrAct = srcAddr[activeSel];
  assign arrWe      = streamOn;
  assign arrWord    = streamOn && streamWord;
  assign arrAddr    = destAddr + ADDR_W'(rdIdx);
  assign arrData    = streamWord ? {mem[streamBuf][rdLo | IDX_W'(1)], mem[streamBuf][rdLo]}
                                 : {8'h00, mem[streamBuf][rdLo]};

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamOn && $past(streamOn)) |-> (arrAddr == $past(arrAddr) + ADDR_W'(1)));
endmodule

// File: rtl/pbuf_top.sv
module pbuf_top
  import pbuf_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordMode,
  input  logic              busWr,
  input  logic [1:0]        busOp,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busData,
  output logic              activeSel,
  output logic [1:0]        bufReady,
  output logic              errFlag,
  output logic              arrWe,
  output logic              arrWord,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [15:0]       arrData
);
  dpStrobe_t         stb;
  logic              streamOn, streamBuf, streamWord;
  logic [7:0]        rdIdx;
  logic [ADDR_W-1:0] destAddr, srcAddrAct;

  pbuf_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordMode(wordMode), .busWr(busWr), .busOp(busOp),
    .busAddr(busAddr), .busData(busData), .srcAddrAct(srcAddrAct), .stb(stb),
    .streamOn(streamOn), .rdIdx(rdIdx), .streamBuf(streamBuf), .streamWord(streamWord),
    .destAddr(destAddr), .activeSel(activeSel), .errFlag(errFlag), .bufReady(bufReady)
  );

  pbuf_data #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busData(busData),
    .activeSel(activeSel), .streamOn(streamOn), .rdIdx(rdIdx), .streamBuf(streamBuf),
    .streamWord(streamWord), .destAddr(destAddr), .srcAddrAct(srcAddrAct),
    .arrWe(arrWe), .arrWord(arrWord), .arrAddr(arrAddr), .arrData(arrData)
  );
endmodule

// File: tb/pbuf_top_tb.sv
module pbuf_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wordMode = 1'b0;
  logic          busWr = 1'b0;
  logic [1:0]    busOp = 2'd0;
  logic [AW-1:0] busAddr = '0;
  logic [15:0]   busData = '0;
  logic          activeSel, errFlag, arrWe, arrWord;
  logic [1:0]    bufReady;
  logic [AW-1:0] arrAddr;
  logic [15:0]   arrData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbuf_top #(.ADDR_W(AW), .PAGE_BYTES(256)) u_dut (
    .clk(clk), .rstN(rstN), .wordMode(wordMode), .busWr(busWr), .busOp(busOp),
    .busAddr(busAddr), .busData(busData), .activeSel(activeSel), .bufReady(bufReady),
    .errFlag(errFlag), .arrWe(arrWe), .arrWord(arrWord), .arrAddr(arrAddr), .arrData(arrData)
  );

  // behavioural reference
  int mMem [2][256];
  int mSrc [2];
  int mCnt [2];
  bit mWd [2];
  bit mOk [2];
  int mAct, mErr, mPhase, mCntLow, mItem, mStrBuf;
  bit mLdWord;
  int qAddr[$];
  int qData[$];
  bit qWord[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mErr = 0; mPhase = 0; mItem = 0; mCntLow = 0; mStrBuf = 0;
      for (int b = 0; b < 2; b++) begin mOk[b] = 0; mSrc[b] = 0; end
      qAddr.delete(); qData.delete(); qWord.delete();
    end else if (qAddr.size() > 0) begin
      void'(qAddr.pop_front()); void'(qData.pop_front()); void'(qWord.pop_front());
    end else if (busWr) begin
      case (mPhase)
        0: case (busOp)
             2'd1: begin mPhase = 1; mLdWord = wordMode; mErr = 0; end
             2'd2: begin mAct = 1 - mAct; mErr = 0; end
             2'd3: if (mOk[mAct] && int'(busAddr) == mSrc[mAct]) begin
                     mErr = 0; mStrBuf = mAct;
                     for (int k = 0; k <= mCnt[mAct]; k++) begin
                       qAddr.push_back(int'(busAddr) + k);
                       qData.push_back(mWd[mAct] ? (mMem[mAct][2*k+1] << 8) | mMem[mAct][2*k]
                                                 : mMem[mAct][k]);
                       qWord.push_back(mWd[mAct]);
                     end
                   end else mErr = 1;
             default: ;
           endcase
        1: begin mCntLow = busData[7:0]; mPhase = 2; end
        2: if (busData[7:0] != 0 || (mLdWord && mCntLow >= 128)) begin mErr = 1; mPhase = 0; end
           else begin mPhase = 3; mItem = 0; end
        default: begin
          if (mItem == 0) mSrc[mAct] = int'(busAddr);
          if (mLdWord) begin
            mMem[mAct][2*mItem] = busData[7:0]; mMem[mAct][2*mItem+1] = busData[15:8];
          end else mMem[mAct][mItem] = busData[7:0];
          if (mItem == mCntLow) begin
            mPhase = 0; mCnt[mAct] = mCntLow; mWd[mAct] = mLdWord; mOk[mAct] = 1;
          end
          mItem++;
        end
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    bit expWe;
    expWe = qAddr.size() > 0;
    check("R10 arrWe", int'(arrWe), int'(expWe));
    if (expWe) begin
      check("R2 arrAddr", int'(arrAddr), qAddr[0]);
      check("R2 arrData", int'(arrData), qData[0]);
      check("R3 arrWord", int'(arrWord), int'(qWord[0]));
    end
    check("R9 bufReady", int'(bufReady), expWe ? (mStrBuf == 1 ? 1 : 2) : 3);
    check("R6 activeSel", int'(activeSel), mAct);
    check("R11 errFlag", int'(errFlag), mErr);
  end

  task automatic bw(input logic [1:0] op, input int addr, input int data);
    busWr = 1'b1; busOp = op; busAddr = AW'(addr); busData = 16'(data);
    @(negedge clk);
    busWr = 1'b0; busOp = 2'd0;
  endtask

  task automatic idle(input int n);
    busWr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 activeSel", int'(activeSel), 0);
    check("R1 bufReady", int'(bufReady), 3);
    check("R1 errFlag", int'(errFlag), 0);
    check("R1 arrWe", int'(arrWe), 0);
    // R8 page write on never-loaded store
    bw(2'd3, 0, 0);
    check("R8 errFlag", int'(errFlag), 1);
    check("R8 arrWe", int'(arrWe), 0);
    // R2 R12 byte load of 4 items into store 0
    bw(2'd1, 0, 0);
    check("R11 errFlag cleared by load", int'(errFlag), 0);
    bw(2'd0, 0, 8'h03); bw(2'd0, 0, 8'h00);
    for (int k = 0; k < 4; k++) bw(2'd0, 100 + k, 16'h55A0 + k);
    bw(2'd3, 100, 0);
    check("R12 arrAddr first", int'(arrAddr), 100);
    check("R2 arrData first", int'(arrData), 16'h00A0);
    check("R9 bufReady", int'(bufReady), 2);
    bw(2'd2, 0, 0);               // R10 swap during stream
    idle(4);
    check("R10 activeSel", int'(activeSel), 0);
    check("R2 arrWe after stream", int'(arrWe), 0);
    // R3 word load into store 1, count 00h with junk in upper bytes
    bw(2'd2, 0, 0);
    wordMode = 1'b1;
    bw(2'd1, 0, 0); wordMode = 1'b0;
    bw(2'd0, 0, 16'hAB00); bw(2'd0, 0, 16'h1200);
    bw(2'd0, 500, 16'hBEEF);
    bw(2'd3, 500, 0);
    check("R3 arrData", int'(arrData), 16'hBEEF);
    check("R3 arrWord", int'(arrWord), 1);
    check("R9 bufReady store1", int'(bufReady), 1);
    idle(1);
    check("R3 single word", int'(arrWe), 0);
    // R7 mismatched destination
    bw(2'd3, 501, 0);
    check("R7 errFlag", int'(errFlag), 1);
    check("R7 arrWe", int'(arrWe), 0);
    // R6 R11 swap back, store 0 kept its data
    bw(2'd2, 0, 0);
    check("R11 errFlag", int'(errFlag), 0);
    check("R6 activeSel", int'(activeSel), 0);
    bw(2'd3, 100, 0);
    check("R6 store0 data", int'(arrData), 16'h00A0);
    idle(4);
    // R4 nonzero high count
    bw(2'd1, 0, 0); bw(2'd0, 0, 8'h02); bw(2'd0, 0, 8'h01);
    check("R4 errFlag", int'(errFlag), 1);
    bw(2'd3, 100, 0);             // decoded as command
    check("R4 old contents", int'(arrData), 16'h00A0);
    idle(4);
    // R5 word count too large
    wordMode = 1'b1;
    bw(2'd1, 0, 0); wordMode = 1'b0;
    bw(2'd0, 0, 8'h80); bw(2'd0, 0, 8'h00);
    check("R5 errFlag", int'(errFlag), 1);
    bw(2'd0, 0, 0);
    check("R11 nop keeps errFlag", int'(errFlag), 1);
    // R2 full 256-byte load into store 1
    bw(2'd2, 0, 0);
    bw(2'd1, 0, 0); bw(2'd0, 0, 8'hFF); bw(2'd0, 0, 8'h00);
    for (int k = 0; k < 256; k++) bw(2'd0, 2048 + k, (k * 7 + 3) & 255);
    bw(2'd3, 2048, 0);
    idle(255);
    check("R2 last item", int'(arrData), (255 * 7 + 3) & 255);
    check("R2 last addr", int'(arrAddr), 2048 + 255);
    idle(1);
    check("R2 done", int'(arrWe), 0);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule